// File: doc/BRIEF.md
# Dual-Channel Pressure Alarm Comparator

This block turns the corrected pressure value of a bridge-sensor conditioner into two alarm pins. Each channel holds its own comparison settings: a primary threshold, a secondary threshold used only for band comparison, a hysteresis width, a polarity bit, and separate assert and release delays counted in millisecond ticks. A channel works either against a single threshold, alarming above or below it, or against a band, alarming inside or outside it.

Samples reach the block as a 15-bit word with a valid strobe. A static control bit selects whether the word and the thresholds are two's complement or unsigned. The comparison state changes only when a strobed sample arrives. The delay counters advance only on the tick input. No temperature value has a path into the block. An enable bit per channel, and a serial-mode input that takes over the pin of the last channel, force the affected outputs low and clear that channel's state.

Top module: `press_alarm`

## Requirements
- R1: After reset both alarm outputs are 0 and every delay counter and comparison state is cleared.
- R2: With band mode off and polarity 1 (above), the condition sets when the sample is greater than the primary threshold. It clears when the sample is less than the threshold minus the hysteresis, and holds for any value in between.
- R3: With band mode off and polarity 0 (below), the condition sets when the sample is less than the primary threshold. It clears when the sample is greater than the threshold plus the hysteresis, and holds in between.
- R4: With band mode on, the sample is inside when secondary ≤ sample ≤ primary. Once inside, it stays inside until the sample falls below secondary minus the hysteresis or rises above primary plus the hysteresis. Polarity 1 alarms inside and polarity 0 alarms outside. No condition is reported before the first sample after the channel is enabled.
- R5: When smp_signed is 1, samples and thresholds compare as 15-bit two's complement. When it is 0, they compare as unsigned.
- R6: With a nonzero assert delay D, the output rises on the D-th tick that arrives while the condition stays true. Any sample that clears the condition restarts the count.
- R7: With a nonzero release delay D, the output falls on the D-th tick that arrives while the condition stays false. Any sample that sets the condition again restarts the count.
- R8: With a delay of 0, the output follows the condition on the clock edge after the sample is taken, which is two edges after the strobe is first presented.
- R9: A sample presented without smp_vld changes neither the comparison state nor the output.
- R10: The two channels are independent. Each uses only its own configuration.
- R11: A channel whose ch_en bit is 0 drives 0. While spi_mode is 1, channel 1 drives 0 and is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| smp_vld | input | 1 | Sample strobe |
| smp_val | input | 15 | Corrected pressure sample |
| smp_signed | input | 1 | 1 = two's complement compare |
| ms_tick | input | 1 | Millisecond tick for the delays |
| spi_mode | input | 1 | Serial mode owns channel 1 pin |
| ch_en | input | 2 | Per-channel enable |
| mode_win | input | 2 | Per-channel band mode |
| mode_pol | input | 2 | Per-channel polarity (above/inside = 1) |
| thr_hi | input | 2x15 | Primary (upper) threshold |
| thr_lo | input | 2x15 | Secondary (lower) threshold |
| hyst | input | 2x15 | Hysteresis width, unsigned |
| on_dly | input | 2x8 | Assert delay in ticks |
| off_dly | input | 2x8 | Release delay in ticks |
| alarm_o | output | 2 | Alarm outputs |

## Verification
The assertions watch several rules on every cycle. The comparison state stays frozen without a strobe. A sample past the threshold or inside the band sets the condition on the next cycle. The output only ever moves toward the present condition, and it never moves without a tick unless the delay is zero. A disabled or serial-mode channel is low one cycle later. The bench scenarios cover what a single cycle cannot show: the hysteresis hold region in each mode, exact tick counts before assert and release, restart of a count after a broken condition, the signed/unsigned difference for the same bit pattern, and independence between the channels.

// File: rtl/press_alarm_pkg.sv
package press_alarm_pkg;
  typedef enum logic [1:0] {
    MODE_BELOW   = 2'd0,
    MODE_ABOVE   = 2'd1,
    MODE_OUTSIDE = 2'd2,
    MODE_INSIDE  = 2'd3
  } cmp_mode_t;

  function automatic cmp_mode_t decode_mode(input logic win, input logic pol);
    return cmp_mode_t'({win, pol});
  endfunction
endpackage

// File: rtl/press_alarm_zone.sv
module press_alarm_zone
  import press_alarm_pkg::*;
#(
  parameter int SW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          valid,
  input  logic [SW-1:0] value,
  input  logic          sgn,
  input  cmp_mode_t     mode,
  input  logic [SW-1:0] thr_hi,
  input  logic [SW-1:0] thr_lo,
  input  logic [SW-1:0] hyst,
  output logic          cond
);
  localparam int EW = SW + 2;

  function automatic logic signed [EW-1:0] widen(input logic [SW-1:0] v, input logic s);
    return s ? EW'($signed(v)) : $signed({2'b00, v});
  endfunction

  function automatic logic zone_next(input logic cur, input cmp_mode_t m,
                                     input logic signed [EW-1:0] v,
                                     input logic signed [EW-1:0] hi,
                                     input logic signed [EW-1:0] lo,
                                     input logic signed [EW-1:0] hy);
    logic set_c, clr_c;
    case (m)
      MODE_ABOVE: begin set_c = v > hi; clr_c = v < hi - hy; end
      MODE_BELOW: begin set_c = v < hi; clr_c = v > hi + hy; end
      default: begin
        set_c = (v >= lo) && (v <= hi);
        clr_c = (v < lo - hy) || (v > hi + hy);
      end
    endcase
    if (set_c)      return 1'b1;
    else if (clr_c) return 1'b0;
    else            return cur;
  endfunction

  logic signed [EW-1:0] sv, shi, slo, shy;
  logic zone_q, primed_q;

  assign sv  = widen(value, sgn);
  assign shi = widen(thr_hi, sgn);
  assign slo = widen(thr_lo, sgn);
  assign shy = $signed({2'b00, hyst});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zone_q   <= 1'b0;
      primed_q <= 1'b0;
    end else if (!en) begin
      zone_q   <= 1'b0;
      primed_q <= 1'b0;
    end else if (valid) begin
      zone_q   <= zone_next(zone_q, mode, sv, shi, slo, shy);
      primed_q <= 1'b1;
    end
  end

  assign cond = primed_q & ((mode == MODE_OUTSIDE) ? ~zone_q : zone_q);

  p_hold_no_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !valid) |=> $stable(zone_q));
  p_above_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && valid && mode == MODE_ABOVE && sv > shi) |=> cond);
  p_inside_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && valid && mode == MODE_INSIDE && sv >= slo && sv <= shi) |=> cond);
endmodule

// File: rtl/press_alarm_delay.sv
module press_alarm_delay #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cond,
  input  logic          tick,
  input  logic [DW-1:0] on_dly,
  input  logic [DW-1:0] off_dly,
  output logic          out_q
);
  function automatic logic expired(input logic [DW-1:0] cnt, input logic [DW-1:0] lim,
                                   input logic tk);
    return (lim == '0) || (tk && ({1'b0, cnt} + 1'b1 >= {1'b0, lim}));
  endfunction

  logic [DW-1:0] cnt_q, dly_sel;
  logic pending, fire;

  assign dly_sel = cond ? on_dly : off_dly;
  assign pending = cond != out_q;
  assign fire    = pending && expired(cnt_q, dly_sel, tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (!en) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (!pending) begin
      cnt_q <= '0;
    end else if (fire) begin
      out_q <= cond;
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_moves_toward_cond_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(out_q) && $past(en)) |-> (out_q == $past(cond)));
  p_no_move_without_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && !$past(tick) && $past(dly_sel) != '0) |-> $stable(out_q));
endmodule

// File: rtl/press_alarm.sv
module press_alarm
  import press_alarm_pkg::*;
#(
  parameter int SW  = 15,
  parameter int DW  = 8,
  parameter int NCH = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_vld,
  input  logic [SW-1:0]           smp_val,
  input  logic                    smp_signed,
  input  logic                    ms_tick,
  input  logic                    spi_mode,
  input  logic [NCH-1:0]          ch_en,
  input  logic [NCH-1:0]          mode_win,
  input  logic [NCH-1:0]          mode_pol,
  input  logic [NCH-1:0][SW-1:0]  thr_hi,
  input  logic [NCH-1:0][SW-1:0]  thr_lo,
  input  logic [NCH-1:0][SW-1:0]  hyst,
  input  logic [NCH-1:0][DW-1:0]  on_dly,
  input  logic [NCH-1:0][DW-1:0]  off_dly,
  output logic [NCH-1:0]          alarm_o
);
  localparam int SHARED_CH = NCH - 1;

  logic [NCH-1:0] eff_en, cond_w;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    if (c == SHARED_CH) begin : g_shared
      assign eff_en[c] = ch_en[c] & ~spi_mode;
    end else begin : g_plain
      assign eff_en[c] = ch_en[c];
    end

    press_alarm_zone #(.SW(SW)) u_zone (
      .clk(clk), .rst_n(rst_n), .en(eff_en[c]), .valid(smp_vld),
      .value(smp_val), .sgn(smp_signed),
      .mode(decode_mode(mode_win[c], mode_pol[c])),
      .thr_hi(thr_hi[c]), .thr_lo(thr_lo[c]), .hyst(hyst[c]),
      .cond(cond_w[c])
    );

    press_alarm_delay #(.DW(DW)) u_delay (
      .clk(clk), .rst_n(rst_n), .en(eff_en[c]), .cond(cond_w[c]),
      .tick(ms_tick), .on_dly(on_dly[c]), .off_dly(off_dly[c]),
      .out_q(alarm_o[c])
    );

    p_disabled_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[c] |=> !alarm_o[c]);
  end

  p_spi_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    spi_mode |=> !alarm_o[SHARED_CH]);
endmodule

// File: tb/press_alarm_bench.sv
module press_alarm_bench;
  localparam int SW = 15;
  localparam int DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic smp_vld = 1'b0, smp_signed = 1'b0, ms_tick = 1'b0, spi_mode = 1'b0;
  logic [SW-1:0] smp_val = '0;
  logic [1:0] ch_en = '0, mode_win = '0, mode_pol = '0;
  logic [1:0][SW-1:0] thr_hi = '0, thr_lo = '0, hyst = '0;
  logic [1:0][DW-1:0] on_dly = '0, off_dly = '0;
  logic [1:0] alarm_o;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  press_alarm u_press_alarm (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_val(smp_val),
    .smp_signed(smp_signed), .ms_tick(ms_tick), .spi_mode(spi_mode),
    .ch_en(ch_en), .mode_win(mode_win), .mode_pol(mode_pol),
    .thr_hi(thr_hi), .thr_lo(thr_lo), .hyst(hyst),
    .on_dly(on_dly), .off_dly(off_dly), .alarm_o(alarm_o)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic send(input logic [SW-1:0] v);
    smp_val = v; smp_vld = 1'b1;
    cyc(1);
    smp_vld = 1'b0;
    cyc(1);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin ms_tick = 1'b1; cyc(1); ms_tick = 1'b0; cyc(1); end
  endtask

  task automatic setup(input int c, input logic w, input logic p, input logic [SW-1:0] hi,
                       input logic [SW-1:0] lo, input logic [SW-1:0] hy,
                       input logic [DW-1:0] ond, input logic [DW-1:0] offd);
    ch_en[c] = 1'b0; cyc(1);
    mode_win[c] = w; mode_pol[c] = p; thr_hi[c] = hi; thr_lo[c] = lo;
    hyst[c] = hy; on_dly[c] = ond; off_dly[c] = offd;
    ch_en[c] = 1'b1; cyc(1);
  endtask

  task automatic t_reset;
    chk(alarm_o[0], 1'b0, "R1 ch0 after reset");
    chk(alarm_o[1], 1'b0, "R1 ch1 after reset");
  endtask

  task automatic t_above;
    setup(0, 0, 1, 15'd1000, 15'd0, 15'd100, 8'd0, 8'd0);
    send(15'd1000); chk(alarm_o[0], 1'b0, "R2 equal not above");
    send(15'd1001); chk(alarm_o[0], 1'b1, "R2 above sets");
    send(15'd950);  chk(alarm_o[0], 1'b1, "R2 hold in hysteresis");
    send(15'd899);  chk(alarm_o[0], 1'b0, "R2 below band clears");
  endtask

  task automatic t_below;
    setup(0, 0, 0, 15'd1000, 15'd0, 15'd100, 8'd0, 8'd0);
    send(15'd999);  chk(alarm_o[0], 1'b1, "R3 below sets");
    send(15'd1050); chk(alarm_o[0], 1'b1, "R3 hold in hysteresis");
    send(15'd1101); chk(alarm_o[0], 1'b0, "R3 above band clears");
  endtask

  task automatic t_window;
    setup(0, 1, 1, 15'd400, 15'd200, 15'd50, 8'd0, 8'd0);
    cyc(2); chk(alarm_o[0], 1'b0, "R4 nothing before first sample");
    send(15'd100); chk(alarm_o[0], 1'b0, "R4 inside mode, below band");
    send(15'd200); chk(alarm_o[0], 1'b1, "R4 lower edge inside");
    send(15'd440); chk(alarm_o[0], 1'b1, "R4 upper hysteresis hold");
    send(15'd451); chk(alarm_o[0], 1'b0, "R4 beyond upper band");
    send(15'd420); chk(alarm_o[0], 1'b0, "R4 no re-entry in hysteresis");
    send(15'd400); chk(alarm_o[0], 1'b1, "R4 upper edge inside");
    send(15'd160); chk(alarm_o[0], 1'b1, "R4 lower hysteresis hold");
    send(15'd149); chk(alarm_o[0], 1'b0, "R4 beyond lower band");
    setup(0, 1, 0, 15'd400, 15'd200, 15'd50, 8'd0, 8'd0);
    cyc(2); chk(alarm_o[0], 1'b0, "R4 outside mode silent before sample");
    send(15'd300); chk(alarm_o[0], 1'b0, "R4 outside mode, inside band");
    send(15'd500); chk(alarm_o[0], 1'b1, "R4 outside mode alarms");
    send(15'd440); chk(alarm_o[0], 1'b1, "R4 outside stays outside");
    send(15'd350); chk(alarm_o[0], 1'b0, "R4 outside mode re-entry");
  endtask

  task automatic t_signed;
    smp_signed = 1'b1;
    setup(0, 0, 1, 15'h7F9C, 15'd0, 15'd50, 8'd0, 8'd0);
    send(15'h7FCE); chk(alarm_o[0], 1'b1, "R5 -50 above -100");
    send(15'h7F74); chk(alarm_o[0], 1'b1, "R5 -140 holds");
    send(15'h7F69); chk(alarm_o[0], 1'b0, "R5 -151 clears");
    setup(0, 0, 1, 15'd100, 15'd0, 15'd0, 8'd0, 8'd0);
    send(15'h7FFF); chk(alarm_o[0], 1'b0, "R5 signed -1 not above 100");
    smp_signed = 1'b0;
    setup(0, 0, 1, 15'd100, 15'd0, 15'd0, 8'd0, 8'd0);
    send(15'h7FFF); chk(alarm_o[0], 1'b1, "R5 unsigned 32767 above 100");
  endtask

  task automatic t_delays;
    setup(0, 0, 1, 15'd1000, 15'd0, 15'd0, 8'd3, 8'd2);
    send(15'd2000); ticks(2); chk(alarm_o[0], 1'b0, "R6 two of three ticks");
    send(15'd500);  send(15'd2000);
    ticks(2); chk(alarm_o[0], 1'b0, "R6 count restarted after break");
    ticks(1); chk(alarm_o[0], 1'b1, "R6 third tick asserts");
    send(15'd500); ticks(1); chk(alarm_o[0], 1'b1, "R7 one of two ticks");
    send(15'd2000); send(15'd500);
    ticks(1); chk(alarm_o[0], 1'b1, "R7 count restarted after break");
    ticks(1); chk(alarm_o[0], 1'b0, "R7 second tick releases");
  endtask

  task automatic t_zero_delay;
    setup(0, 0, 1, 15'd1000, 15'd0, 15'd0, 8'd0, 8'd0);
    smp_val = 15'd3000; smp_vld = 1'b1; cyc(1); smp_vld = 1'b0;
    chk(alarm_o[0], 1'b0, "R8 not yet after first edge");
    cyc(1); chk(alarm_o[0], 1'b1, "R8 high after second edge");
  endtask

  task automatic t_no_valid;
    setup(0, 0, 1, 15'd1000, 15'd0, 15'd0, 8'd0, 8'd0);
    smp_val = 15'd5000; cyc(3); ticks(2);
    chk(alarm_o[0], 1'b0, "R9 unstrobed value ignored");
    send(15'd500); chk(alarm_o[0], 1'b0, "R9 strobed low value");
  endtask

  task automatic t_indep;
    setup(0, 0, 1, 15'd1000, 15'd0, 15'd0, 8'd0, 8'd0);
    setup(1, 0, 0, 15'd1000, 15'd0, 15'd0, 8'd0, 8'd0);
    send(15'd2000);
    chk(alarm_o[0], 1'b1, "R10 ch0 above"); chk(alarm_o[1], 1'b0, "R10 ch1 not below");
    send(15'd500);
    chk(alarm_o[0], 1'b0, "R10 ch0 cleared"); chk(alarm_o[1], 1'b1, "R10 ch1 below");
  endtask

  task automatic t_enable;
    ch_en[0] = 1'b0; send(15'd2000);
    chk(alarm_o[0], 1'b0, "R11 disabled channel low");
    send(15'd500); chk(alarm_o[1], 1'b1, "R11 ch1 active before serial mode");
    spi_mode = 1'b1; cyc(1);
    chk(alarm_o[1], 1'b0, "R11 serial mode forces ch1 low");
    send(15'd400); chk(alarm_o[1], 1'b0, "R11 serial mode holds ch1 low");
    spi_mode = 1'b0; cyc(1);
    send(15'd400); chk(alarm_o[1], 1'b1, "R11 ch1 back after serial mode");
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset;
    t_above;
    t_below;
    t_window;
    t_signed;
    t_delays;
    t_zero_delay;
    t_no_valid;
    t_indep;
    t_enable;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule